// File: doc/BRIEF.md
# Monochrome Passive LCD Timing Generator

This block generates the panel-side timing for a single-panel monochrome passive LCD with an 8-bit data path. It divides the memory clock down to a pixel step (Ts). It runs a horizontal counter in Ts units and a vertical line counter. From these two counters it produces the line pulse, the frame pulse, the shift clock, the AC-bias (MOD) toggle and the two 4-bit data groups. All edges sit at fixed Ts offsets from the start of each line.

Display bytes are fetched through a single-cycle request. The block raises `pixReq` for one memory clock, and the source must present the byte on `pixData` in that same cycle. That byte is driven to the panel on the shift clock rising edge that follows.

The active configuration has four inputs: the divide select, the display width, the non-display width and the line count. All four are captured during reset and again each time a frame ends. Changes made in the middle of a frame are therefore held off until the next frame starts.

Top module: `lcd_mono_timing`

## Requirements
- R1: A synchronous reset drives every panel output low and restarts at line 0 of a frame. The first line after reset raises the line pulse, frame pulse and MOD in the same step.
- R2: One Ts lasts `divSel`+1 memory clocks. Consecutive line pulse rising edges are ((hdWidth+1)*8 + (hndWidth+1)*8 + 33) Ts apart.
- R3: The line pulse is high for exactly 9 Ts, starting at the beginning of each line.
- R4: Each line carries hdWidth+1 shift clock periods, each 4 Ts high and 4 Ts low. The first rising edge comes 20 Ts after the line pulse falls. The shift clock is never high while the line pulse is high.
- R5: The frame pulse rises 14 Ts after the line pulse falls on the last line of a frame. It falls 14 Ts after the line pulse falls on line 0, so it is high for one full line period.
- R6: `pixReq` is high for one memory clock, in the clock just before each shift clock rising edge. The byte on `pixData` in that clock drives bits 7:4 onto `dataUpper` and bits 3:0 onto `dataLower` at that rising edge. The data outputs change at no other time.
- R7: MOD (`acBias`) inverts exactly once per frame, in the same step as the line pulse of line 0 rises.
- R8: A frame holds lineCount+1 lines (lineCount ≥ 1).
- R9: Configuration inputs changed in the middle of a frame have no effect until the next frame begins.
- R10: The last shift clock falling edge of a line comes (8*hndWidth + 16) Ts before the next line pulse rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| divSel | input | 2 | Pixel step = divSel+1 memory clocks |
| hdWidth | input | 7 | Display width in 8-pixel units, minus one |
| hndWidth | input | 5 | Non-display width in 8-pixel units, minus one |
| lineCount | input | 10 | Lines per frame minus one |
| pixReq | output | 1 | Byte fetch strobe |
| pixData | input | 8 | Byte returned in the same clock as pixReq |
| framePulse | output | 1 | Frame start pulse |
| linePulse | output | 1 | Line pulse |
| shiftClk | output | 1 | Data shift clock |
| acBias | output | 1 | MOD (AC-bias) signal |
| dataUpper | output | 4 | Upper data group |
| dataLower | output | 4 | Lower data group |

## Verification
Every panel output is registered on the memory clock in which the pixel step ends. An output therefore changes one Ts after the counter reaches its slot, and `pixReq` leads the matching shift clock rise by exactly one memory clock. The bench samples on the falling clock edge and timestamps every output transition. It then compares the gaps between transitions against integer multiples of the expected Ts, rather than against absolute cycle numbers. Each byte is checked at the shift clock falling edge, 4 Ts after it was driven. Configuration changes are applied only while line 1 is in progress, far from any frame boundary, so the frame in which a change may first appear is unambiguous.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int LINE_TS       = 9;
  localparam int SHIFT_LEAD_TS = 20;
  localparam int FRAME_HOLD_TS = 14;
  localparam int OVERHEAD_TS   = 33;
  localparam int SHIFT_START   = LINE_TS + SHIFT_LEAD_TS;
  localparam int FRAME_EDGE    = LINE_TS + FRAME_HOLD_TS;

  typedef struct packed {
    logic tick;      // pixel step ends this clock
    logic lineOn;
    logic frameOn;
    logic shiftOn;
    logic loadByte;
    logic modFlip;
  } lcdStrobe_t;
endpackage

// File: rtl/lcdt_ctrl.sv
module lcdt_ctrl
  import lcdt_pkg::*;
#(
  parameter int HD_W  = 7,
  parameter int HND_W = 5,
  parameter int V_W   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       divSel,
  input  logic [HD_W-1:0]  hdWidth,
  input  logic [HND_W-1:0] hndWidth,
  input  logic [V_W-1:0]   lineCount,
  output lcdStrobe_t       strobe,
  output logic             pixReq
);
  localparam int H_W = $clog2(((2**HD_W) + (2**HND_W)) * 8 + OVERHEAD_TS + 1);

  logic [1:0]       cfgDiv, divCnt;
  logic [HD_W-1:0]  cfgHd;
  logic [HND_W-1:0] cfgHnd;
  logic [V_W-1:0]   cfgLines, vCnt;
  logic [H_W-1:0]   hCnt, hdLen, hndLen, lastH, shiftOff;
  logic             inWindow, tick, lineEnd, frameEnd;

  assign hdLen    = (H_W'(cfgHd) + H_W'(1)) << 3;
  assign hndLen   = (H_W'(cfgHnd) + H_W'(1)) << 3;
  assign lastH    = hdLen + hndLen + H_W'(OVERHEAD_TS - 1);
  assign tick     = (divCnt == cfgDiv);
  assign lineEnd  = (hCnt == lastH);
  assign frameEnd = lineEnd && (vCnt == cfgLines);

  assign shiftOff = hCnt - H_W'(SHIFT_START);
  assign inWindow = (hCnt >= H_W'(SHIFT_START)) && (hCnt < H_W'(SHIFT_START) + hdLen);

  always_comb begin
    strobe.tick     = tick;
    strobe.lineOn   = hCnt < H_W'(LINE_TS);
    strobe.frameOn  = ((vCnt == '0) && (hCnt < H_W'(FRAME_EDGE))) ||
                      ((vCnt == cfgLines) && (hCnt >= H_W'(FRAME_EDGE)));
    strobe.shiftOn  = inWindow && !shiftOff[2];
    strobe.loadByte = inWindow && (shiftOff[2:0] == 3'd0);
    strobe.modFlip  = (vCnt == '0) && (hCnt == '0);
  end

  assign pixReq = tick && strobe.loadByte;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgDiv   <= divSel;
      cfgHd    <= hdWidth;
      cfgHnd   <= hndWidth;
      cfgLines <= lineCount;
      divCnt   <= '0;
      hCnt     <= '0;
      vCnt     <= '0;
    end else if (tick) begin
      divCnt <= '0;
      if (lineEnd) begin
        hCnt <= '0;
        if (frameEnd) begin
          vCnt     <= '0;
          cfgDiv   <= divSel;
          cfgHd    <= hdWidth;
          cfgHnd   <= hndWidth;
          cfgLines <= lineCount;
        end else begin
          vCnt <= vCnt + V_W'(1);
        end
      end else begin
        hCnt <= hCnt + H_W'(1);
      end
    end else begin
      divCnt <= divCnt + 2'd1;
    end
  end
endmodule

// File: rtl/lcdt_dpath.sv
module lcdt_dpath
  import lcdt_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  lcdStrobe_t         strobe,
  input  logic [PIX_W-1:0]   pixData,
  output logic               framePulse,
  output logic               linePulse,
  output logic               shiftClk,
  output logic               acBias,
  output logic [PIX_W/2-1:0] dataUpper,
  output logic [PIX_W/2-1:0] dataLower
);
  localparam int HALF = PIX_W / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      framePulse <= 1'b0;
      linePulse  <= 1'b0;
      shiftClk   <= 1'b0;
      acBias     <= 1'b0;
      dataUpper  <= '0;
      dataLower  <= '0;
    end else if (strobe.tick) begin
      framePulse <= strobe.frameOn;
      linePulse  <= strobe.lineOn;
      shiftClk   <= strobe.shiftOn;
      if (strobe.modFlip) acBias <= ~acBias;
      if (strobe.loadByte) begin
        dataUpper <= pixData[PIX_W-1:HALF];
        dataLower <= pixData[HALF-1:0];
      end
    end
  end
endmodule

// File: rtl/lcd_mono_timing.sv
module lcd_mono_timing
  import lcdt_pkg::*;
#(
  parameter int HD_W  = 7,
  parameter int HND_W = 5,
  parameter int V_W   = 10,
  parameter int PIX_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         divSel,
  input  logic [HD_W-1:0]    hdWidth,
  input  logic [HND_W-1:0]   hndWidth,
  input  logic [V_W-1:0]     lineCount,
  output logic               pixReq,
  input  logic [PIX_W-1:0]   pixData,
  output logic               framePulse,
  output logic               linePulse,
  output logic               shiftClk,
  output logic               acBias,
  output logic [PIX_W/2-1:0] dataUpper,
  output logic [PIX_W/2-1:0] dataLower
);
  lcdStrobe_t strobe;

  lcdt_ctrl #(.HD_W(HD_W), .HND_W(HND_W), .V_W(V_W)) u_ctrl (
    .clk(clk), .rst(rst), .divSel(divSel), .hdWidth(hdWidth),
    .hndWidth(hndWidth), .lineCount(lineCount), .strobe(strobe), .pixReq(pixReq)
  );

  lcdt_dpath #(.PIX_W(PIX_W)) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .pixData(pixData),
    .framePulse(framePulse), .linePulse(linePulse), .shiftClk(shiftClk),
    .acBias(acBias), .dataUpper(dataUpper), .dataLower(dataLower)
  );
endmodule

// File: rtl/lcdt_checker.sv
module lcdt_checker #(
  parameter int PIX_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               pixReq,
  input logic               framePulse,
  input logic               linePulse,
  input logic               shiftClk,
  input logic               acBias,
  input logic [PIX_W/2-1:0] dataUpper,
  input logic [PIX_W/2-1:0] dataLower
);
  logic wasRst = 1'b0;
  always_ff @(posedge clk) wasRst <= rst;

  always @(posedge clk) begin
    if (wasRst) begin
      a_r1_reset_low: assert (!framePulse && !linePulse && !shiftClk && !acBias &&
                              (dataUpper == '0) && (dataLower == '0));
    end
  end

  a_r4_no_shift_in_line: assert property (@(posedge clk) disable iff (rst)
    linePulse |-> !shiftClk);

  a_r6_req_then_rise: assert property (@(posedge clk) disable iff (rst)
    pixReq |=> $rose(shiftClk));

  a_r6_data_only_at_rise: assert property (@(posedge clk) disable iff (rst)
    !$stable({dataUpper, dataLower}) |-> $rose(shiftClk));

  a_r7_mod_at_line_rise: assert property (@(posedge clk) disable iff (rst)
    !$stable(acBias) |-> $rose(linePulse));

  a_r5_frame_fall_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(framePulse) |-> (!linePulse && !shiftClk));
endmodule

bind lcd_mono_timing lcdt_checker #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst(rst), .pixReq(pixReq), .framePulse(framePulse),
  .linePulse(linePulse), .shiftClk(shiftClk), .acBias(acBias),
  .dataUpper(dataUpper), .dataLower(dataLower)
);

// File: tb/lcd_mono_timing_tb.sv
module lcd_mono_timing_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] divSel = '0;
  logic [6:0] hdWidth = '0;
  logic [4:0] hndWidth = '0;
  logic [9:0] lineCount = 10'd1;
  logic       pixReq;
  logic [7:0] pixData;
  logic       framePulse, linePulse, shiftClk, acBias;
  logic [3:0] dataUpper, dataLower;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_mono_timing u_dut (
    .clk(clk), .rst(rst), .divSel(divSel), .hdWidth(hdWidth), .hndWidth(hndWidth),
    .lineCount(lineCount), .pixReq(pixReq), .pixData(pixData),
    .framePulse(framePulse), .linePulse(linePulse), .shiftClk(shiftClk),
    .acBias(acBias), .dataUpper(dataUpper), .dataLower(dataLower)
  );

  int vectors = 0;
  int fails   = 0;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  function automatic int lenTs(int hd, int hnd);
    return (hd + 1) * 8 + (hnd + 1) * 8 + 33;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // byte source: answers each request in the same clock
  int reqIdx = 0;
  assign pixData = pat(reqIdx);
  always @(posedge clk) begin
    if (rst) reqIdx <= 0;
    else if (pixReq) reqIdx <= reqIdx + 1;
  end

  logic rstSeen = 1'b0;
  always @(posedge clk) rstSeen <= rst;

  // monitor state
  int tnow = 0;
  int ts, aHd, aHnd, aLines, curHd, curHnd, curL, lineIdx;
  int lineRiseT, lineFallT, shiftRiseT, shiftFallT, frameRiseT, frameRiseL;
  int shiftsInLine, linesInFrame, frameCount, fallIdx;
  bit seenLine, firstFrame, frameRiseValid, cfgChanged;
  logic pLine, pFrame, pShift, pMod, pReq;
  logic [7:0] pData;
  logic lr, lf, sr, sf, fr, ff, mc, dc;

  always @(negedge clk) begin
    tnow++;
    if (rstSeen) begin
      // R1: everything low after a reset edge
      chk(!framePulse && !linePulse && !shiftClk && !acBias && dataUpper == 0 && dataLower == 0,
          "R1", int'({framePulse, linePulse, shiftClk, acBias, dataUpper, dataLower}), 0);
      aHd = int'(hdWidth); aHnd = int'(hndWidth); aLines = int'(lineCount); ts = int'(divSel) + 1;
      curHd = aHd; curHnd = aHnd; curL = lenTs(aHd, aHnd);
      lineIdx = -1; seenLine = 0; firstFrame = 1; frameRiseValid = 0; cfgChanged = 0;
      shiftsInLine = 0; linesInFrame = 0; frameCount = 0; fallIdx = 0;
      pLine = 0; pFrame = 0; pShift = 0; pMod = 0; pReq = 0; pData = '0;
    end else begin
      lr = linePulse && !pLine;   lf = !linePulse && pLine;
      sr = shiftClk && !pShift;   sf = !shiftClk && pShift;
      fr = framePulse && !pFrame; ff = !framePulse && pFrame;
      mc = (acBias != pMod);      dc = ({dataUpper, dataLower} != pData);

      if (lr) begin
        if (seenLine) begin
          chk(tnow - lineRiseT == curL * ts, cfgChanged ? "R9" : "R2", tnow - lineRiseT, curL * ts);
          chk(shiftsInLine == curHd + 1, "R4", shiftsInLine, curHd + 1);
          chk(tnow - shiftFallT == (8 * curHnd + 16) * ts, "R10", tnow - shiftFallT, (8 * curHnd + 16) * ts);
        end
        lineRiseT = tnow; seenLine = 1; shiftsInLine = 0;
        lineIdx++;
        if (lineIdx > aLines) lineIdx = 0;
        if (lineIdx == 0) begin
          if (frameCount > 0) chk(linesInFrame == aLines + 1, "R8", linesInFrame, aLines + 1);
          linesInFrame = 0;
          aHd = int'(hdWidth); aHnd = int'(hndWidth); aLines = int'(lineCount);
          frameCount++;
        end
        linesInFrame++;
        curHd = aHd; curHnd = aHnd; curL = lenTs(aHd, aHnd);
        chk(mc == (lineIdx == 0), "R7", int'(mc), int'(lineIdx == 0));
      end else if (mc) begin
        chk(0, "R7", 1, 0);
      end

      if (lf) begin
        chk(tnow - lineRiseT == 9 * ts, "R3", tnow - lineRiseT, 9 * ts);
        lineFallT = tnow;
      end

      if (sr || pReq) chk(sr == pReq, "R6", int'(sr), int'(pReq));

      if (sr) begin
        if (shiftsInLine == 0) chk(tnow - lineFallT == 20 * ts, "R4", tnow - lineFallT, 20 * ts);
        else chk(tnow - shiftFallT == 4 * ts, "R4", tnow - shiftFallT, 4 * ts);
        chk(!linePulse, "R4", int'(linePulse), 0);
        shiftRiseT = tnow;
      end

      if (sf) begin
        chk(tnow - shiftRiseT == 4 * ts, "R4", tnow - shiftRiseT, 4 * ts);
        chk({dataUpper, dataLower} == pat(fallIdx), "R6", int'({dataUpper, dataLower}), int'(pat(fallIdx)));
        fallIdx++; shiftsInLine++; shiftFallT = tnow;
      end

      if (dc && !sr) chk(0, "R6", int'({dataUpper, dataLower}), int'(pData));

      if (fr) begin
        if (firstFrame) begin
          chk(lr && lineIdx == 0 && frameCount == 1, "R1", lineIdx, 0);
          firstFrame = 0;
        end else begin
          chk(lineIdx == aLines && tnow - lineFallT == 14 * ts, "R5", tnow - lineFallT, 14 * ts);
          frameRiseT = tnow; frameRiseL = curL; frameRiseValid = 1;
        end
      end

      if (ff) begin
        chk(lineIdx == 0 && tnow - lineFallT == 14 * ts, "R5", tnow - lineFallT, 14 * ts);
        if (frameRiseValid) chk(tnow - frameRiseT == frameRiseL * ts, "R5", tnow - frameRiseT, frameRiseL * ts);
        frameRiseValid = 0;
      end

      pLine = linePulse; pFrame = framePulse; pShift = shiftClk;
      pMod = acBias; pReq = pixReq; pData = {dataUpper, dataLower};
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      vectors++; fails++;
      $display("FAIL R2 watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic runCase(int dv, int hd, int hnd, int lines, int frames);
    @(negedge clk);
    divSel = 2'(dv); hdWidth = 7'(hd); hndWidth = 5'(hnd); lineCount = 10'(lines);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    while (frameCount < frames + 1) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // directed corners
    runCase(0, 0, 0, 1, 2);   // narrowest line, fastest step
    runCase(3, 5, 5, 3, 2);   // slowest step
    runCase(1, 0, 5, 2, 2);   // wide blanking
    runCase(2, 6, 0, 1, 2);   // wide display, narrow blanking
    // constrained random
    for (int i = 0; i < 6; i++) begin
      runCase(int'($urandom_range(0, 3)), int'($urandom_range(0, 5)),
              int'($urandom_range(0, 5)), int'($urandom_range(1, 3)), 2);
    end
    // R9: change widths and line count in mid-frame
    runCase(2, 2, 1, 2, 1);
    while (lineIdx != 1) @(negedge clk);
    hdWidth = 7'd4; hndWidth = 5'd3; lineCount = 10'd3; cfgChanged = 1;
    while (frameCount < 4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule